// File: doc/BRIEF.md
# Bus Release and Low-Power Interlock

This block settles contention between an outside master that wants the shared external bus and the chip's own power-down and memory-refresh machinery. The outside master asks for the bus with an active-low request. The block answers with a grant once the internal bus engine reports an idle boundary. A CPU sleep strobe is decoded into one of three low-power targets. The decode uses the clock-stop enable, the standby select and the two module-stop words. The deep targets (all clocks stopped, software standby) are never entered while the bus is lent out. Such a request is parked and carried out as soon as the bus returns.

The block also keeps a refresh request pending while the bus is lent out. It grants that request with a one-cycle pulse once the bus is back. If enabled, it raises a request-out line that asks the outside master to hand the bus back early. An interrupt input wakes the chip. On exit from standby, a programmable oscillator-settle count runs before any bus request is honoured.

Top module: `bus_release_interlock`

## Requirements
- R1: After reset the grant, request-out and refresh pulse are low and the power state is RUN (0). When `breq_n_i` falls while the bus is idle and the state allows release, `bus_grant_o` rises on the third rising clock edge after the low level is first sampled (two synchroniser stages plus one grant register).
- R2: The grant is only given in a cycle where `bus_idle_i` is high. A request seen while it is low waits, and is granted one edge after idle returns.
- R3: When `breq_n_i` returns high, `bus_grant_o` falls on the third rising edge after the high level is first sampled.
- R4: A sleep strobe seen in RUN changes `pwr_state_o` on the next edge. The encodings are 0 RUN, 1 SLEEP, 2 ALLSTOP, 3 STANDBY and 4 SETTLE. Standby select high picks STANDBY. Otherwise ALLSTOP is picked when clock-stop enable is high, the extended stop word is all ones, and the stop word is all ones or all ones except bit 0. Every other case picks SLEEP.
- R5: In SLEEP, bus requests are still granted. In ALLSTOP, STANDBY and SETTLE the grant stays low; a request held through ALLSTOP is granted one edge after the wake-up returns the state to RUN.
- R6: A strobe for ALLSTOP or STANDBY while the grant is high leaves the state in RUN. The parked target is entered on the edge after the one where the grant falls.
- R7: A second deep-target strobe while one is parked replaces the parked target.
- R8: The wake interrupt moves SLEEP and ALLSTOP to RUN on the next edge, and STANDBY to SETTLE. SETTLE lasts `settle_cnt_i`+1 cycles and then goes to RUN. No grant is given before RUN.
- R9: A refresh request pulse produces a one-cycle `rfsh_gnt_o` two edges later when the bus is owned internally. During release, the pulse comes on the edge after the grant falls.
- R10: With `reqout_en_i` high, `breq_out_o` rises one edge after a refresh is pending during release and falls one edge after the grant falls. With `reqout_en_i` low it stays low.
- R11: A strobe that decodes to SLEEP enters SLEEP at once, even while the bus is released. It also discards any parked deep target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| breq_n_i | input | 1 | External bus request, active low, asynchronous |
| bus_idle_i | input | 1 | Internal bus engine is at an idle boundary |
| sleep_stb_i | input | 1 | CPU sleep instruction strobe |
| mstop_i | input | MSTP_W | Module-stop word |
| xmstop_i | input | MSTP_W | Extended module-stop word |
| clkstop_en_i | input | 1 | Allow the all-clocks-stopped state |
| standby_sel_i | input | 1 | Sleep strobe selects software standby |
| wake_irq_i | input | 1 | Wake-up interrupt |
| settle_cnt_i | input | SETTLE_W | Oscillator settle cycles on standby exit |
| rfsh_req_i | input | 1 | Refresh request pulse |
| reqout_en_i | input | 1 | Enable request-out during release |
| bus_grant_o | output | 1 | Bus granted to the external master |
| pwr_state_o | output | 3 | Power state code |
| breq_out_o | output | 1 | Ask external master to return the bus |
| rfsh_gnt_o | output | 1 | One-cycle refresh grant |

## Verification
The decoder is driven with random module-stop words biased toward all ones, all ones minus bit 0 and near misses, crossed with random enable and select bits. This separates the exact ALLSTOP match from SLEEP, and checks that standby select overrides the rest. Directed sequences then place sleep strobes before, during and after a release. These tell an immediate entry from a parked one, and a replaced parked target from a dropped one. Refresh pulses are placed both with the bus owned and with it lent out, with request-out enabled and disabled. This separates the pending path from the direct path.

// File: rtl/bri_pkg.sv
package bri_pkg;
   typedef enum logic [2:0] {
      PS_RUN     = 3'd0,
      PS_SLEEP   = 3'd1,
      PS_ALLSTOP = 3'd2,
      PS_STANDBY = 3'd3,
      PS_SETTLE  = 3'd4
   } pstate_e;
endpackage

// File: rtl/bri_req_sync.sv
module bri_req_sync #(
   parameter int STAGES     = 2,
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic req_o
);
   localparam logic IDLE_LVL = ACTIVE_LOW;

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= IDLE_LVL;
      else        chain_q[0] <= raw_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= IDLE_LVL;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   if (ACTIVE_LOW) begin : g_low
      assign req_o = ~chain_q[STAGES-1];
   end else begin : g_high
      assign req_o = chain_q[STAGES-1];
   end
endmodule

// File: rtl/bri_power_fsm.sv
module bri_power_fsm
   import bri_pkg::*;
#(
   parameter int          MSTP_W     = 16,
   parameter int          SETTLE_W   = 8,
   parameter logic [MSTP_W-1:0] KEEP_MASK = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_stb_i,
   input  logic [MSTP_W-1:0]   mstop_i,
   input  logic [MSTP_W-1:0]   xmstop_i,
   input  logic                clkstop_en_i,
   input  logic                standby_sel_i,
   input  logic                wake_irq_i,
   input  logic [SETTLE_W-1:0] settle_cnt_i,
   input  logic                released_i,
   output pstate_e             state_o,
   output logic                bus_ok_o
);
   localparam logic [MSTP_W-1:0] ALL_ONES = '1;

   pstate_e             state_q, state_n;
   pstate_e             park_q, park_n, tgt_c;
   logic                parked_q, parked_n;
   logic [SETTLE_W-1:0] cnt_q, cnt_n;
   logic                deep_go;
   logic                stop_match;

   assign stop_match = clkstop_en_i && (xmstop_i == ALL_ONES)
                       && ((mstop_i | KEEP_MASK) == ALL_ONES);

   always_comb begin
      if (standby_sel_i)   tgt_c = PS_STANDBY;
      else if (stop_match) tgt_c = PS_ALLSTOP;
      else                 tgt_c = PS_SLEEP;
   end

   always_comb begin
      state_n  = state_q;
      park_n   = park_q;
      parked_n = parked_q;
      cnt_n    = cnt_q;
      deep_go  = 1'b0;
      unique case (state_q)
         PS_RUN: begin
            if (sleep_stb_i) begin
               if (tgt_c == PS_SLEEP) begin
                  state_n  = PS_SLEEP;
                  parked_n = 1'b0;
               end else if (released_i) begin
                  parked_n = 1'b1;
                  park_n   = tgt_c;
               end else begin
                  state_n  = tgt_c;
                  parked_n = 1'b0;
                  deep_go  = 1'b1;
               end
            end else if (parked_q && !released_i) begin
               state_n  = park_q;
               parked_n = 1'b0;
               deep_go  = 1'b1;
            end
         end
         PS_SLEEP, PS_ALLSTOP: begin
            if (wake_irq_i) state_n = PS_RUN;
         end
         PS_STANDBY: begin
            if (wake_irq_i) begin
               state_n = PS_SETTLE;
               cnt_n   = settle_cnt_i;
            end
         end
         PS_SETTLE: begin
            if (cnt_q == '0) state_n = PS_RUN;
            else             cnt_n   = cnt_q - 1'b1;
         end
         default: state_n = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PS_RUN;
         park_q   <= PS_SLEEP;
         parked_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         state_q  <= state_n;
         park_q   <= park_n;
         parked_q <= parked_n;
         cnt_q    <= cnt_n;
      end
   end

   assign state_o  = state_q;
   assign bus_ok_o = ((state_q == PS_RUN) || (state_q == PS_SLEEP)) && !deep_go;
endmodule

// File: rtl/bri_release_arb.sv
module bri_release_arb (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic bus_idle_i,
   input  logic bus_ok_i,
   input  logic rfsh_req_i,
   input  logic reqout_en_i,
   output logic grant_o,
   output logic rfsh_gnt_o,
   output logic breq_out_o
);
   logic rel_q;
   logic rf_pend_q;
   logic rf_gnt_q;
   logic rq_out_q;
   logic rf_fire;

   assign rf_fire = rf_pend_q && !rel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q     <= 1'b0;
         rf_pend_q <= 1'b0;
         rf_gnt_q  <= 1'b0;
         rq_out_q  <= 1'b0;
      end else begin
         if (!rel_q) rel_q <= req_i && bus_idle_i && bus_ok_i && !rf_pend_q;
         else        rel_q <= req_i;
         rf_pend_q <= rfsh_req_i || (rf_pend_q && !rf_fire);
         rf_gnt_q  <= rf_fire;
         rq_out_q  <= reqout_en_i && rf_pend_q && rel_q;
      end
   end

   assign grant_o    = rel_q;
   assign rfsh_gnt_o = rf_gnt_q;
   assign breq_out_o = rq_out_q;
endmodule

// File: rtl/bus_release_interlock.sv
module bus_release_interlock
   import bri_pkg::*;
#(
   parameter int MSTP_W      = 16,
   parameter int SETTLE_W    = 8,
   parameter int SYNC_STAGES = 2,
   parameter logic [MSTP_W-1:0] KEEP_MASK = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                breq_n_i,
   input  logic                bus_idle_i,
   input  logic                sleep_stb_i,
   input  logic [MSTP_W-1:0]   mstop_i,
   input  logic [MSTP_W-1:0]   xmstop_i,
   input  logic                clkstop_en_i,
   input  logic                standby_sel_i,
   input  logic                wake_irq_i,
   input  logic [SETTLE_W-1:0] settle_cnt_i,
   input  logic                rfsh_req_i,
   input  logic                reqout_en_i,
   output logic                bus_grant_o,
   output logic [2:0]          pwr_state_o,
   output logic                breq_out_o,
   output logic                rfsh_gnt_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MSTP_W < 2) begin : g_bad_mstp
      $error("MSTP_W must be at least 2");
   end
   if (SETTLE_W < 1) begin : g_bad_settle
      $error("SETTLE_W must be at least 1");
   end

   logic    req_s;
   logic    bus_ok;
   pstate_e state;

   bri_req_sync #(.STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (breq_n_i),
      .req_o (req_s)
   );

   bri_power_fsm #(.MSTP_W(MSTP_W), .SETTLE_W(SETTLE_W), .KEEP_MASK(KEEP_MASK)) u_pwr (
      .clk           (clk),
      .rst_n         (rst_n),
      .sleep_stb_i   (sleep_stb_i),
      .mstop_i       (mstop_i),
      .xmstop_i      (xmstop_i),
      .clkstop_en_i  (clkstop_en_i),
      .standby_sel_i (standby_sel_i),
      .wake_irq_i    (wake_irq_i),
      .settle_cnt_i  (settle_cnt_i),
      .released_i    (bus_grant_o),
      .state_o       (state),
      .bus_ok_o      (bus_ok)
   );

   bri_release_arb u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_s),
      .bus_idle_i  (bus_idle_i),
      .bus_ok_i    (bus_ok),
      .rfsh_req_i  (rfsh_req_i),
      .reqout_en_i (reqout_en_i),
      .grant_o     (bus_grant_o),
      .rfsh_gnt_o  (rfsh_gnt_o),
      .breq_out_o  (breq_out_o)
   );

   assign pwr_state_o = state;
endmodule

// File: rtl/bus_release_interlock_chk.sv
module bus_release_interlock_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_idle_i,
   input logic       bus_grant_o,
   input logic [2:0] pwr_state_o,
   input logic       breq_out_o,
   input logic       rfsh_gnt_o
);
   AST_DEEP_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state_o >= 3'd2) |-> !bus_grant_o); // R5

   AST_GRANT_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_grant_o) |-> $past(bus_idle_i)); // R2

   AST_DEEP_ENTRY_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwr_state_o == 3'd2 || pwr_state_o == 3'd3) && $past(pwr_state_o) == 3'd0)
      |-> !$past(bus_grant_o)); // R6

   AST_STANDBY_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state_o == 3'd0) |-> ($past(pwr_state_o) != 3'd3)); // R8

   AST_REFRESH_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_gnt_o |-> !bus_grant_o); // R9

   AST_REQOUT_IN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      breq_out_o |-> $past(bus_grant_o)); // R10
endmodule

bind bus_release_interlock bus_release_interlock_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_idle_i  (bus_idle_i),
   .bus_grant_o (bus_grant_o),
   .pwr_state_o (pwr_state_o),
   .breq_out_o  (breq_out_o),
   .rfsh_gnt_o  (rfsh_gnt_o)
);

// File: tb/bus_release_interlock_tb.sv
module bus_release_interlock_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        breq_n = 1'b1;
   logic        bus_idle = 1'b1;
   logic        sleep_stb = 1'b0;
   logic [15:0] mstop = '0;
   logic [15:0] xmstop = '0;
   logic        clkstop_en = 1'b0;
   logic        standby_sel = 1'b0;
   logic        wake_irq = 1'b0;
   logic [7:0]  settle_cnt = 8'd3;
   logic        rfsh_req = 1'b0;
   logic        reqout_en = 1'b0;
   logic        grant;
   logic [2:0]  pwr;
   logic        breq_out;
   logic        rfsh_gnt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bus_release_interlock u_dut (
      .clk(clk), .rst_n(rst_n), .breq_n_i(breq_n), .bus_idle_i(bus_idle),
      .sleep_stb_i(sleep_stb), .mstop_i(mstop), .xmstop_i(xmstop),
      .clkstop_en_i(clkstop_en), .standby_sel_i(standby_sel),
      .wake_irq_i(wake_irq), .settle_cnt_i(settle_cnt),
      .rfsh_req_i(rfsh_req), .reqout_en_i(reqout_en),
      .bus_grant_o(grant), .pwr_state_o(pwr), .breq_out_o(breq_out),
      .rfsh_gnt_o(rfsh_gnt)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic strobe;
      sleep_stb = 1'b1; step(1); sleep_stb = 1'b0;
   endtask

   task automatic wake;
      wake_irq = 1'b1; step(1); wake_irq = 1'b0;
   endtask

   task automatic take_bus;
      breq_n = 1'b0; step(3);
   endtask

   task automatic give_back;
      breq_n = 1'b1; step(3);
   endtask

   task automatic cfg_allstop;
      standby_sel = 1'b0; clkstop_en = 1'b1; mstop = 16'hFFFE; xmstop = 16'hFFFF;
   endtask

   function automatic logic [2:0] exp_target(input logic [15:0] m, input logic [15:0] xm,
                                             input logic cse, input logic sby);
      if (sby) return 3'd3;
      if (cse && xm == 16'hFFFF && (m == 16'hFFFF || m == 16'hFFFE)) return 3'd2;
      return 3'd1;
   endfunction

   function automatic logic [15:0] pick_word(input int sel);
      case (sel)
         0: return 16'hFFFF;
         1: return 16'hFFFE;
         2: return 16'hFFFC;
         default: return 16'($urandom);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd2024));
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 reset grant", grant, 0);
      chk("R1 reset state", pwr, 0);
      chk("R1 reset reqout", breq_out, 0);
      chk("R1 reset refresh", rfsh_gnt, 0);

      // R1 grant latency
      breq_n = 1'b0; step(2);
      chk("R1 grant early", grant, 0);
      step(1);
      chk("R1 grant", grant, 1);
      // R3 release latency
      breq_n = 1'b1; step(2);
      chk("R3 still granted", grant, 1);
      step(1);
      chk("R3 released", grant, 0);

      // R2 idle boundary
      bus_idle = 1'b0; breq_n = 1'b0; step(5);
      chk("R2 held while busy", grant, 0);
      bus_idle = 1'b1; step(1);
      chk("R2 granted at idle", grant, 1);
      give_back();

      // R4 / R5 ordinary sleep keeps release working
      clkstop_en = 1'b0; strobe();
      chk("R4 sleep entry", pwr, 1);
      take_bus();
      chk("R5 grant in sleep", grant, 1);
      chk("R5 still sleep", pwr, 1);
      give_back();
      wake();
      chk("R8 wake from sleep", pwr, 0);

      // R5 all-clocks-stopped blocks grant
      cfg_allstop(); strobe();
      chk("R4 allstop entry", pwr, 2);
      breq_n = 1'b0; step(6);
      chk("R5 no grant in allstop", grant, 0);
      wake();
      chk("R8 wake from allstop", pwr, 0);
      step(1);
      chk("R5 grant after wake", grant, 1);

      // R6 deferred entry
      strobe();
      chk("R6 deferred", pwr, 0);
      breq_n = 1'b1; step(2);
      chk("R6 still run", pwr, 0);
      step(1);
      chk("R6 grant dropped", grant, 0);
      chk("R6 not yet entered", pwr, 0);
      step(1);
      chk("R6 entered after recovery", pwr, 2);
      wake();

      // R7 overwrite parked target, then R8 settle
      take_bus();
      strobe();
      standby_sel = 1'b1; strobe();
      chk("R7 still run", pwr, 0);
      breq_n = 1'b1; step(4);
      chk("R7 overwritten target", pwr, 3);
      settle_cnt = 8'd4; breq_n = 1'b0; step(4);
      chk("R8 no grant in standby", grant, 0);
      wake();
      chk("R8 settle", pwr, 4);
      step(4);
      chk("R8 still settling", pwr, 4);
      chk("R8 no grant settling", grant, 0);
      step(1);
      chk("R8 run after settle", pwr, 0);
      chk("R8 grant not yet", grant, 0);
      step(1);
      chk("R8 grant after settle", grant, 1);
      standby_sel = 1'b0;

      // R11 plain sleep overrides parked target
      cfg_allstop(); strobe();
      clkstop_en = 1'b0; strobe();
      chk("R11 immediate sleep", pwr, 1);
      chk("R11 grant kept", grant, 1);
      wake();
      give_back(); step(1);
      chk("R11 parked dropped", pwr, 0);

      // R9 / R10 refresh during release with request-out
      take_bus();
      reqout_en = 1'b1;
      rfsh_req = 1'b1; step(1); rfsh_req = 1'b0;
      step(1);
      chk("R10 reqout raised", breq_out, 1);
      chk("R9 no refresh in release", rfsh_gnt, 0);
      breq_n = 1'b1; step(3);
      chk("R10 grant dropped", grant, 0);
      chk("R10 reqout one more cycle", breq_out, 1);
      step(1);
      chk("R10 reqout dropped", breq_out, 0);
      chk("R9 refresh after recovery", rfsh_gnt, 1);
      step(1);
      chk("R9 refresh pulse ends", rfsh_gnt, 0);

      // R10 disabled request-out
      reqout_en = 1'b0;
      take_bus();
      rfsh_req = 1'b1; step(1); rfsh_req = 1'b0;
      step(3);
      chk("R10 reqout disabled", breq_out, 0);
      give_back(); step(2);

      // R9 refresh with bus owned
      rfsh_req = 1'b1; step(1); rfsh_req = 1'b0;
      chk("R9 owned early", rfsh_gnt, 0);
      step(1);
      chk("R9 owned pulse", rfsh_gnt, 1);
      step(1);
      chk("R9 owned pulse ends", rfsh_gnt, 0);

      // R4 random decode
      for (int i = 0; i < 40; i++) begin
         logic [2:0] e;
         int s;
         mstop       = pick_word($urandom % 5);
         xmstop      = pick_word($urandom % 4);
         clkstop_en  = 1'($urandom);
         standby_sel = (($urandom % 4) == 0);
         e = exp_target(mstop, xmstop, clkstop_en, standby_sel);
         strobe();
         chk("R4 random decode", pwr, e);
         if (e == 3'd3) begin
            s = $urandom % 6;
            settle_cnt = 8'(s);
            wake();
            chk("R8 random settle", pwr, 4);
            step(s);
            chk("R8 random settle hold", pwr, 4);
            step(1);
         end else begin
            wake();
         end
         chk("R8 random wake", pwr, 0);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule